// File: doc/BRIEF.md
# Dual-View Aliased Register File

This block holds eight 80-bit storage entries that are reached through two views. The stack view treats the entries as an 80-bit register stack: its indices are offsets from a 3-bit top-of-stack pointer, and it has push and pop controls that move the pointer. The packed view treats the same entries as eight directly numbered 64-bit registers and works on the low 64 bits of each entry. A write through either view is seen by the next read through the other view, because both views share one physical array.

A write through the packed view also fills the upper 16 bits of its entry with ones. It resets the stack pointer to zero, so the two index spaces line up again after a switch of view. A per-entry flag vector shows which entries carry that all-ones marker, which means they hold packed data. All reads are combinational from the stored state, and every update takes effect at the clock edge. Arithmetic, exceptions and state save/restore belong to surrounding logic.

Top module: `alias_regfile`

## Requirements
- R1: An active-low asynchronous reset clears all eight 80-bit entries to zero and sets the stack pointer `top_o` to 0.
- R2: Packed read port A/B at index n returns bits 63:0 of physical entry n.
- R3: A packed write to index n stores `pk_wdata` in bits 63:0 of entry n and sets bits 79:64 to 16'hFFFF.
- R4: A packed write sets `top_o` to 0 at that clock edge. This overrides any push or pop in the same cycle.
- R5: Stack read port A/B at index i returns all 80 bits of physical entry (top_o + i) mod 8, using the pointer value held before the edge.
- R6: A push alone decrements `top_o` and a pop alone increments it, both modulo 8. Push and pop together, or neither, leave it unchanged.
- R7: A stack write at index i goes to entry (T' + i) mod 8. T' is the pointer after this cycle's push or pop, not counting a packed-write reset. So a push and a write together target the new top.
- R8: When a stack write and a packed write reach the same physical entry in one cycle, the packed write is the one stored.
- R9: Bit n of `packed_map` is 1 exactly when bits 79:64 of entry n are all ones.
- R10: A read of an entry written in the same cycle returns the old value. The new value is visible through both views from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_push | input | 1 | Decrement stack pointer |
| st_pop | input | 1 | Increment stack pointer |
| st_we | input | 1 | Stack-view write enable |
| st_waddr | input | 3 | Stack-relative write index |
| st_wdata | input | 80 | Stack-view write data |
| st_raddr_a | input | 3 | Stack-relative read index, port A |
| st_rdata_a | output | 80 | Stack-view read data, port A |
| st_raddr_b | input | 3 | Stack-relative read index, port B |
| st_rdata_b | output | 80 | Stack-view read data, port B |
| pk_we | input | 1 | Packed-view write enable |
| pk_waddr | input | 3 | Packed register write number |
| pk_wdata | input | 64 | Packed-view write data |
| pk_raddr_a | input | 3 | Packed register read number, port A |
| pk_rdata_a | output | 64 | Packed-view read data, port A |
| pk_raddr_b | input | 3 | Packed register read number, port B |
| pk_rdata_b | output | 64 | Packed-view read data, port B |
| top_o | output | 3 | Current stack pointer |
| packed_map | output | 8 | Per-entry packed-data flag |

## Verification
The hardest cases to reach are those where several controls meet in one cycle. Examples are a push with a stack write, whose target depends on the pointer after it moves, and a stack write and a packed write that hit the same entry while the pointer is being reset. Reaching them from random stimulus would need a lucky match of pointer value, stack offset and packed number. So directed steps first put the pointer at a known nonzero value. They then compute the stack offset that hits the chosen packed number and raise every control together. After that, random cycles with a fixed seed mix all controls freely, and every read is compared with a bench model before and after each edge.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;
  localparam int unsigned RF_ENTRIES = 8;
  localparam int unsigned RF_AW      = $clog2(RF_ENTRIES);
  localparam int unsigned RF_W       = 80;
  localparam int unsigned RF_PW      = 64;
  localparam int unsigned RF_HW      = RF_W - RF_PW;

  typedef logic [RF_AW-1:0] rf_idx_t;
  typedef logic [RF_W-1:0]  rf_entry_t;
  typedef logic [RF_PW-1:0] rf_pword_t;

  // physical slot for a stack-relative index; wraps by width
  function automatic rf_idx_t stack_to_phys(input rf_idx_t top, input rf_idx_t off);
    return rf_idx_t'(top + off);
  endfunction

  // stack pointer after one cycle of push/pop controls
  function automatic rf_idx_t next_top(input rf_idx_t top, input logic push, input logic pop);
    rf_idx_t t;
    t = top;
    if (push && !pop) t = rf_idx_t'(top - 1'b1);
    else if (pop && !push) t = rf_idx_t'(top + 1'b1);
    return t;
  endfunction

  // packed data widened to a full entry with the marker field set
  function automatic rf_entry_t widen_packed(input rf_pword_t d);
    return {{RF_HW{1'b1}}, d};
  endfunction

  function automatic logic marker_set(input rf_entry_t e);
    return &e[RF_W-1:RF_PW];
  endfunction
endpackage

// File: rtl/alias_rf_topptr.sv
module alias_rf_topptr
  import alias_rf_pkg::*;
#(
  parameter int unsigned AW = RF_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          pk_reset,
  output logic [AW-1:0] top_q,
  output logic [AW-1:0] top_stack_nxt
);
  // pointer after push/pop only; used to place stack writes
  always_comb begin
    top_stack_nxt = top_q;
    if (push && !pop) top_stack_nxt = top_q - 1'b1;
    else if (pop && !push) top_stack_nxt = top_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        top_q <= '0;
    else if (pk_reset) top_q <= '0;
    else               top_q <= top_stack_nxt;
  end
endmodule

// File: rtl/alias_rf_storage.sv
module alias_rf_storage
  import alias_rf_pkg::*;
#(
  parameter int unsigned N  = RF_ENTRIES,
  parameter int unsigned W  = RF_W,
  parameter int unsigned PW = RF_PW,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_we,
  input  logic [AW-1:0]        st_wphys,
  input  logic [W-1:0]         st_wdata,
  input  logic                 pk_we,
  input  logic [AW-1:0]        pk_widx,
  input  logic [PW-1:0]        pk_wdata,
  input  logic [AW-1:0]        rd_idx_0,
  input  logic [AW-1:0]        rd_idx_1,
  input  logic [AW-1:0]        rd_idx_2,
  input  logic [AW-1:0]        rd_idx_3,
  output logic [W-1:0]         rd_data_0,
  output logic [W-1:0]         rd_data_1,
  output logic [W-1:0]         rd_data_2,
  output logic [W-1:0]         rd_data_3,
  output logic [N-1:0][W-1:0]  entries
);
  localparam int unsigned HW = W - PW;

  logic [W-1:0] pk_full;
  assign pk_full = {{HW{1'b1}}, pk_wdata};

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic         hit_pk;
    logic         hit_st;
    logic [W-1:0] ent_q;

    assign hit_pk = pk_we && (pk_widx == AW'(g));
    assign hit_st = st_we && (st_wphys == AW'(g));

    // packed write has priority over a stack write to the same slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (hit_pk) ent_q <= pk_full;
      else if (hit_st) ent_q <= st_wdata;
    end

    assign entries[g] = ent_q;
  end

  // asynchronous reads of stored state give read-before-write
  assign rd_data_0 = entries[rd_idx_0];
  assign rd_data_1 = entries[rd_idx_1];
  assign rd_data_2 = entries[rd_idx_2];
  assign rd_data_3 = entries[rd_idx_3];
endmodule

// File: rtl/alias_rf_marker.sv
module alias_rf_marker #(
  parameter int unsigned N  = 8,
  parameter int unsigned W  = 80,
  parameter int unsigned PW = 64
) (
  input  logic [N-1:0][W-1:0] entries,
  output logic [N-1:0]        flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    assign flags[g] = &entries[g][W-1:PW];
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import alias_rf_pkg::*;
#(
  parameter int unsigned N  = RF_ENTRIES,
  parameter int unsigned W  = RF_W,
  parameter int unsigned PW = RF_PW,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_push,
  input  logic          st_pop,
  input  logic          st_we,
  input  logic [AW-1:0] st_waddr,
  input  logic [W-1:0]  st_wdata,
  input  logic [AW-1:0] st_raddr_a,
  output logic [W-1:0]  st_rdata_a,
  input  logic [AW-1:0] st_raddr_b,
  output logic [W-1:0]  st_rdata_b,
  input  logic          pk_we,
  input  logic [AW-1:0] pk_waddr,
  input  logic [PW-1:0] pk_wdata,
  input  logic [AW-1:0] pk_raddr_a,
  output logic [PW-1:0] pk_rdata_a,
  input  logic [AW-1:0] pk_raddr_b,
  output logic [PW-1:0] pk_rdata_b,
  output logic [AW-1:0] top_o,
  output logic [N-1:0]  packed_map
);
  logic [AW-1:0]       top_q;
  logic [AW-1:0]       top_stack_nxt;
  logic [AW-1:0]       st_wphys;
  logic [AW-1:0]       st_rphys_a;
  logic [AW-1:0]       st_rphys_b;
  logic [W-1:0]        rd_pk_a;
  logic [W-1:0]        rd_pk_b;
  logic [N-1:0][W-1:0] entries;

  alias_rf_topptr #(.AW(AW)) u_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .push          (st_push),
    .pop           (st_pop),
    .pk_reset      (pk_we),
    .top_q         (top_q),
    .top_stack_nxt (top_stack_nxt)
  );

  // stack writes use the moved pointer, reads use the held one
  assign st_wphys   = top_stack_nxt + st_waddr;
  assign st_rphys_a = top_q + st_raddr_a;
  assign st_rphys_b = top_q + st_raddr_b;

  alias_rf_storage #(.N(N), .W(W), .PW(PW), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_we     (st_we),
    .st_wphys  (st_wphys),
    .st_wdata  (st_wdata),
    .pk_we     (pk_we),
    .pk_widx   (pk_waddr),
    .pk_wdata  (pk_wdata),
    .rd_idx_0  (st_rphys_a),
    .rd_idx_1  (st_rphys_b),
    .rd_idx_2  (pk_raddr_a),
    .rd_idx_3  (pk_raddr_b),
    .rd_data_0 (st_rdata_a),
    .rd_data_1 (st_rdata_b),
    .rd_data_2 (rd_pk_a),
    .rd_data_3 (rd_pk_b),
    .entries   (entries)
  );

  alias_rf_marker #(.N(N), .W(W), .PW(PW)) u_mark (
    .entries (entries),
    .flags   (packed_map)
  );

  assign pk_rdata_a = rd_pk_a[PW-1:0];
  assign pk_rdata_b = rd_pk_b[PW-1:0];
  assign top_o      = top_q;

  logic unused_hi;
  assign unused_hi = ^{rd_pk_a[W-1:PW], rd_pk_b[W-1:PW]};
endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned W  = 80,
  parameter int unsigned PW = 64,
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_push,
  input logic          st_pop,
  input logic          st_we,
  input logic [AW-1:0] st_raddr_a,
  input logic [W-1:0]  st_rdata_a,
  input logic          pk_we,
  input logic [AW-1:0] pk_waddr,
  input logic [PW-1:0] pk_wdata,
  input logic [AW-1:0] pk_raddr_a,
  input logic [PW-1:0] pk_rdata_a,
  input logic [AW-1:0] top_o,
  input logic [N-1:0]  packed_map
);
  logic [AW-1:0] st_map_a;
  assign st_map_a = top_o + st_raddr_a;

  a_r4_pk_resets_top: assert property (@(posedge clk) disable iff (!rst_n)
    pk_we |=> (top_o == '0));

  a_r6_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (st_push && !st_pop && !pk_we) |=> (top_o == AW'($past(top_o) - 1'b1)));

  a_r6_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pop && !st_push && !pk_we) |=> (top_o == AW'($past(top_o) + 1'b1)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_push == st_pop && !pk_we) |=> $stable(top_o));

  a_r3_pk_marks: assert property (@(posedge clk) disable iff (!rst_n)
    pk_we |=> packed_map[$past(pk_waddr)]);

  a_r8_pk_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_we && st_we) |=> (packed_map[$past(pk_waddr)] && 1'b1));

  // R2/R5: both views of one physical slot agree on the low field
  a_r5_views_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_raddr_a == st_map_a) |-> (pk_rdata_a == st_rdata_a[PW-1:0]));

  // R9: flag agrees with the marker field of the slot seen by stack port A
  a_r9_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (packed_map[st_map_a] == (&st_rdata_a[W-1:PW])));

  logic unused_d;
  assign unused_d = ^pk_wdata;
endmodule

bind alias_regfile alias_regfile_chk #(.N(N), .W(W), .PW(PW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_push    (st_push),
  .st_pop     (st_pop),
  .st_we      (st_we),
  .st_raddr_a (st_raddr_a),
  .st_rdata_a (st_rdata_a),
  .pk_we      (pk_we),
  .pk_waddr   (pk_waddr),
  .pk_wdata   (pk_wdata),
  .pk_raddr_a (pk_raddr_a),
  .pk_rdata_a (pk_rdata_a),
  .top_o      (top_o),
  .packed_map (packed_map)
);

// File: tb/alias_regfile_bench.sv
`timescale 1ns/1ps
module alias_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_push = 0, st_pop = 0, st_we = 0, pk_we = 0;
  logic [2:0]  st_waddr = 0, st_raddr_a = 0, st_raddr_b = 0;
  logic [2:0]  pk_waddr = 0, pk_raddr_a = 0, pk_raddr_b = 0;
  logic [79:0] st_wdata = 0, st_rdata_a, st_rdata_b;
  logic [63:0] pk_wdata = 0, pk_rdata_a, pk_rdata_b;
  logic [2:0]  top_o;
  logic [7:0]  packed_map;

  int checks = 0;
  int errors = 0;

  logic [79:0] m_ent [8];
  logic [2:0]  m_top;

  always #4 clk = ~clk;

  alias_regfile u_alias_regfile (
    .clk(clk), .rst_n(rst_n), .st_push(st_push), .st_pop(st_pop),
    .st_we(st_we), .st_waddr(st_waddr), .st_wdata(st_wdata),
    .st_raddr_a(st_raddr_a), .st_rdata_a(st_rdata_a),
    .st_raddr_b(st_raddr_b), .st_rdata_b(st_rdata_b),
    .pk_we(pk_we), .pk_waddr(pk_waddr), .pk_wdata(pk_wdata),
    .pk_raddr_a(pk_raddr_a), .pk_rdata_a(pk_rdata_a),
    .pk_raddr_b(pk_raddr_b), .pk_rdata_b(pk_rdata_b),
    .top_o(top_o), .packed_map(packed_map)
  );

  function automatic logic [7:0] exp_map();
    logic [7:0] m;
    for (int k = 0; k < 8; k++) m[k] = (m_ent[k][79:64] == 16'hFFFF);
    return m;
  endfunction

  function automatic logic [2:0] moved(input logic [2:0] t, input logic pu, input logic po);
    if (pu == po) return t;
    return pu ? t - 3'd1 : t + 3'd1;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare every read port against the model for current addresses
  task automatic check_reads(input string tag);
    chk({tag, " R5 st_a"}, st_rdata_a, m_ent[3'(m_top + st_raddr_a)]);
    chk({tag, " R5 st_b"}, st_rdata_b, m_ent[3'(m_top + st_raddr_b)]);
    chk({tag, " R2 pk_a"}, {16'h0, pk_rdata_a}, {16'h0, m_ent[pk_raddr_a][63:0]});
    chk({tag, " R2 pk_b"}, {16'h0, pk_rdata_b}, {16'h0, m_ent[pk_raddr_b][63:0]});
    chk({tag, " R6 top"}, {77'h0, top_o}, {77'h0, m_top});
    chk({tag, " R9 map"}, {72'h0, packed_map}, {72'h0, exp_map()});
  endtask

  // inputs already driven after a negedge; checks before and after edge
  task automatic step(input string tag);
    logic [2:0] ts;
    #1;
    check_reads({tag, " R10 pre"});
    ts = moved(m_top, st_push, st_pop);
    @(posedge clk);
    if (st_we) m_ent[3'(ts + st_waddr)] = st_wdata;
    if (pk_we) m_ent[pk_waddr] = {16'hFFFF, pk_wdata};
    m_top = pk_we ? 3'd0 : ts;
    @(negedge clk);
    st_push = 0; st_pop = 0; st_we = 0; pk_we = 0;
    #1;
    check_reads({tag, " post"});
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] tgt;
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 8; k++) m_ent[k] = '0;
    m_top = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    for (int k = 0; k < 8; k++) begin
      pk_raddr_a = 3'(k); st_raddr_a = 3'(k);
      #1;
      chk("R1 reset st", st_rdata_a, 80'h0);
    end
    chk("R1 reset top", {77'h0, top_o}, 80'h0);
    chk("R1 reset map", {72'h0, packed_map}, 80'h0);

    // R3/R4: packed write marker, visible via stack view next cycle (R10)
    @(negedge clk);
    pk_we = 1; pk_waddr = 3'd5; pk_wdata = 64'hDEAD_BEEF_0123_4567;
    pk_raddr_a = 3'd5; st_raddr_a = 3'd5;
    step("R3 pkw");
    chk("R3 marker", st_rdata_a, 80'hFFFF_DEAD_BEEF_0123_4567);

    // R6: two pushes move top to 6
    st_push = 1; step("R6 push1");
    st_push = 1; step("R6 push2");
    chk("R6 top6", {77'h0, top_o}, {77'h0, 3'd6});
    // R6: push and pop together hold
    st_push = 1; st_pop = 1; step("R6 both");
    // R7: push with write targets new top: top 6 -> 5, offset 0 -> entry 5
    st_push = 1; st_we = 1; st_waddr = 0; st_wdata = 80'h1234_0000_0000_0000_ABCD;
    pk_raddr_a = 3'd5;
    step("R7 push+wr");
    chk("R7 entry5", {16'h0, pk_rdata_a}, {16'h0, 64'h0000_0000_0000_ABCD});
    // R6: pop wraps 7 -> 0
    st_pop = 1; step("R6 pop"); // top 6
    st_pop = 1; step("R6 pop");  // top 7
    st_pop = 1; step("R6 wrap"); // top 0
    chk("R6 wrap0", {77'h0, top_o}, 80'h0);
    st_push = 1; step("R6 wrap7");
    chk("R6 top7", {77'h0, top_o}, {77'h0, 3'd7});

    // R8 + R4: collision with push; stack target (6+i) == 2 -> i = 4
    st_push = 1; st_we = 1; st_waddr = 3'd4; st_wdata = 80'h5555_5555_5555_5555_5555;
    pk_we = 1; pk_waddr = 3'd2; pk_wdata = 64'h0BAD_F00D_0000_0001;
    pk_raddr_b = 3'd2;
    step("R8 collide");
    chk("R8 pk wins", {16'h0, pk_rdata_b}, {16'h0, 64'h0BAD_F00D_0000_0001});
    chk("R4 top0", {77'h0, top_o}, 80'h0);

    // R10: read and write same entry same cycle; step checks old value pre-edge
    st_we = 1; st_waddr = 3'd3; st_raddr_a = 3'd3; st_wdata = 80'h0;
    step("R10 rbw");

    // random mix
    for (int n = 0; n < 600; n++) begin
      st_push = ($urandom % 4) == 0;
      st_pop  = ($urandom % 4) == 0;
      st_we   = ($urandom % 2) == 0;
      pk_we   = ($urandom % 5) == 0;
      st_waddr = 3'($urandom); pk_waddr = 3'($urandom);
      st_raddr_a = 3'($urandom); st_raddr_b = 3'($urandom);
      pk_raddr_a = 3'($urandom); pk_raddr_b = 3'($urandom);
      st_wdata = {16'($urandom), 32'($urandom), 32'($urandom)};
      if (($urandom % 4) == 0) st_wdata[79:64] = 16'hFFFF;
      pk_wdata = {32'($urandom), 32'($urandom)};
      if (($urandom % 6) == 0) begin
        tgt = moved(m_top, st_push, st_pop);
        st_we = 1; pk_we = 1; st_waddr = 3'(pk_waddr - tgt);
      end
      step("rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule